// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It walks a two-level hierarchy of translation tables held in memory. It accepts one request at a time, with a write flag. It takes the physical base of the running process's directory from a base-register input. It then reads two words on a single memory request/acknowledge port: first the directory entry, then the leaf entry of the page table that the directory entry points to.

The walk ends with a one-cycle completion pulse. The pulse carries either a physical address or a fault cause. The block checks three things on the leaf entry: whether the page is in use, whether it is resident, and whether a write is allowed. When a write succeeds on a page that has not yet been marked modified, the block writes the leaf entry back to memory with its modified flag set, before it reports completion. The address is split as a 10-bit directory index, a 10-bit table index and a 12-bit offset within a 4 KB page.

Entry layout, shared by both levels: bit 0 means resident and bit 1 means writable. Bits 31:12 hold the frame number. On a directory entry, this is the frame that holds the page table. Leaf entries also use bit 6 as the modified flag and bits 10:9 for the allocation state: 00 unused, 01 reserved, 10 or 11 committed.

Top module: `pt_walker`

## Requirements
- R1: While reset is held, and in the first cycle after it, `done` and `mem_req` are 0 and `req_ready` is 1.
- R2: The first read of a walk goes to `pd_base + 4*vaddr[31:22]`. The second read goes to `{dir[31:12], 12'b0} + 4*vaddr[21:12]`, where `dir` is the directory entry.
- R3: When no fault is found, the walk reports cause 0 and physical address `{leaf[31:12], vaddr[11:0]}`.
- R4: A directory entry with bit 0 clear ends the walk with cause 1, and no second read is made.
- R5: A leaf entry whose bits 10:9 are 00 gives cause 3. This check takes priority over the resident bit.
- R6: A leaf entry that is in use (reserved or committed) but has bit 0 clear gives cause 2.
- R7: A write request gives cause 4 when bit 1 is clear in the directory entry or in the leaf entry. A read request is not affected by bit 1.
- R8: A write that succeeds on a leaf entry with bit 6 clear issues exactly one memory write of the leaf word with bit 6 set, to the leaf address, before completion. No memory write is made when bit 6 is already set, on a read, or on a fault.
- R9: `done` is high for exactly one cycle per accepted request. On a fault, `rsp_paddr` is 0.
- R10: A request is taken only while `req_ready` is 1. A `req_valid` pulse during a walk starts no second walk and does not change the addresses or the result of the walk in progress.
- R11: While `mem_req` waits for `mem_ack`, the request stays asserted and `mem_addr`, `mem_we` and `mem_wdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_base | input | 32 | Physical address of the current directory |
| req_valid | input | 1 | Translation request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a write access |
| req_ready | output | 1 | Walker idle, request can be taken |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access complete |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| done | output | 1 | One-cycle completion pulse |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_cause | output | 3 | Fault cause: 0 none, 1 directory absent, 2 leaf absent, 3 unused page, 4 write to read-only |

## Verification
The situation that is hardest to reach from the ports is the write-back of the modified flag. Reaching it needs a write request whose directory and leaf entries are both resident, writable and committed, with the flag still clear. The same entry must then show no write-back on a second write. The bench builds such an entry in its memory model and writes to it twice. It compares the recorded memory transactions against its own model's list each time. A `req_valid` pulse is also injected in the middle of a walk, to show that the busy walker ignores it.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE       = 3'd0,
    CAUSE_DIR_ABSENT = 3'd1,
    CAUSE_PTE_ABSENT = 3'd2,
    CAUSE_UNUSED     = 3'd3,
    CAUSE_READ_ONLY  = 3'd4
  } fault_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DIR,
    S_PTE,
    S_WB,
    S_DONE
  } walk_e;

  localparam int BIT_PRESENT  = 0;
  localparam int BIT_WRITABLE = 1;
  localparam int BIT_DIRTY    = 6;
  localparam int COMMIT_LO    = 9;
  localparam logic [1:0] COMMIT_UNUSED = 2'b00;
endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int PA_W  = 32,
  parameter int DIR_W = 10,
  parameter int TBL_W = 10,
  parameter int OFF_W = 12
) (
  input  logic [PA_W-1:0]       pd_base,
  input  logic [DIR_W-1:0]      dir_idx,
  input  logic [TBL_W-1:0]      tbl_idx,
  input  logic [PA_W-OFF_W-1:0] tbl_frame,
  output logic [PA_W-1:0]       dir_addr,
  output logic [PA_W-1:0]       pte_addr
);
  localparam int WORD_SHIFT = 2;

  logic [PA_W-1:0] dir_off, tbl_off, tbl_base;

  always_comb begin
    dir_off  = PA_W'(dir_idx) << WORD_SHIFT;
    tbl_off  = PA_W'(tbl_idx) << WORD_SHIFT;
    tbl_base = {tbl_frame, {OFF_W{1'b0}}};
    dir_addr = pd_base + dir_off;
    pte_addr = tbl_base + tbl_off;
  end
endmodule

// File: rtl/pt_pte_check.sv
module pt_pte_check
  import ptw_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] pte,
  input  logic             dir_writable,
  input  logic             is_write,
  output fault_e           cause
);
  always_comb begin
    if (pte[COMMIT_LO +: 2] == COMMIT_UNUSED) begin
      cause = CAUSE_UNUSED;
    end else if (!pte[BIT_PRESENT]) begin
      cause = CAUSE_PTE_ABSENT;
    end else if (is_write && !(dir_writable && pte[BIT_WRITABLE])) begin
      cause = CAUSE_READ_ONLY;
    end else begin
      cause = CAUSE_NONE;
    end
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int DIR_W = 10,
  parameter int TBL_W = 10,
  parameter int OFF_W = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PA_W-1:0] pd_base,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic            req_write,
  output logic            req_ready,
  output logic            mem_req,
  output logic            mem_we,
  output logic [PA_W-1:0] mem_addr,
  output logic [PA_W-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [PA_W-1:0] mem_rdata,
  output logic            done,
  output logic [PA_W-1:0] rsp_paddr,
  output logic [2:0]      rsp_cause
);
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int DIR_LO  = OFF_W + TBL_W;

  walk_e               state_q, state_d;
  logic [VA_W-1:0]     vaddr_q;
  logic                write_q;
  logic [FRAME_W-1:0]  dframe_q;
  logic                dwr_q;
  logic [PA_W-1:0]     pte_q;
  logic [PA_W-1:0]     paddr_q, paddr_d;
  fault_e              cause_q, cause_d;
  logic                take_req, take_dir, take_pte, take_res;
  logic [PA_W-1:0]     dir_addr, pte_addr;
  fault_e              pte_cause;

  pt_addr_gen #(
    .PA_W(PA_W), .DIR_W(DIR_W), .TBL_W(TBL_W), .OFF_W(OFF_W)
  ) i_addr (
    .pd_base  (pd_base),
    .dir_idx  (vaddr_q[VA_W-1:DIR_LO]),
    .tbl_idx  (vaddr_q[DIR_LO-1:OFF_W]),
    .tbl_frame(dframe_q),
    .dir_addr (dir_addr),
    .pte_addr (pte_addr)
  );

  pt_pte_check #(.ENT_W(PA_W)) i_check (
    .pte         (mem_rdata),
    .dir_writable(dwr_q),
    .is_write    (write_q),
    .cause       (pte_cause)
  );

  // next-state and result logic
  always_comb begin
    state_d  = state_q;
    take_req = 1'b0;
    take_dir = 1'b0;
    take_pte = 1'b0;
    take_res = 1'b0;
    cause_d  = cause_q;
    paddr_d  = paddr_q;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          take_req = 1'b1;
          state_d  = S_DIR;
        end
      end
      S_DIR: begin
        if (mem_ack) begin
          if (!mem_rdata[BIT_PRESENT]) begin
            take_res = 1'b1;
            cause_d  = CAUSE_DIR_ABSENT;
            paddr_d  = '0;
            state_d  = S_DONE;
          end else begin
            take_dir = 1'b1;
            state_d  = S_PTE;
          end
        end
      end
      S_PTE: begin
        if (mem_ack) begin
          take_pte = 1'b1;
          take_res = 1'b1;
          cause_d  = pte_cause;
          paddr_d  = (pte_cause == CAUSE_NONE) ?
                     {mem_rdata[PA_W-1:OFF_W], vaddr_q[OFF_W-1:0]} : '0;
          if (pte_cause == CAUSE_NONE && write_q && !mem_rdata[BIT_DIRTY])
            state_d = S_WB;
          else
            state_d = S_DONE;
        end
      end
      S_WB: begin
        if (mem_ack) state_d = S_DONE;
      end
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      vaddr_q  <= '0;
      write_q  <= 1'b0;
      dframe_q <= '0;
      dwr_q    <= 1'b0;
      pte_q    <= '0;
      paddr_q  <= '0;
      cause_q  <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      if (take_req) begin
        vaddr_q <= req_vaddr;
        write_q <= req_write;
      end
      if (take_dir) begin
        dframe_q <= mem_rdata[PA_W-1:OFF_W];
        dwr_q    <= mem_rdata[BIT_WRITABLE];
      end
      if (take_pte) pte_q <= mem_rdata;
      if (take_res) begin
        paddr_q <= paddr_d;
        cause_q <= cause_d;
      end
    end
  end

  always_comb begin
    req_ready = (state_q == S_IDLE);
    mem_req   = (state_q == S_DIR) || (state_q == S_PTE) || (state_q == S_WB);
    mem_we    = (state_q == S_WB);
    mem_addr  = (state_q == S_DIR) ? dir_addr : pte_addr;
    mem_wdata = pte_q | (PA_W'(1) << BIT_DIRTY);
    done      = (state_q == S_DONE);
    rsp_paddr = paddr_q;
    rsp_cause = cause_q;
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            mem_req,
  input logic            mem_we,
  input logic [PA_W-1:0] mem_addr,
  input logic [PA_W-1:0] mem_wdata,
  input logic            mem_ack,
  input logic            done,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [2:0]      rsp_cause
);
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fault_no_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rsp_cause != 3'd0) |-> (rsp_paddr == '0));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req && !done));

  p_wb_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> mem_wdata[6]);

  p_cause_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rsp_cause <= 3'd4));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .done(done), .rsp_paddr(rsp_paddr), .rsp_cause(rsp_cause)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pd_base;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic        req_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;
  logic        done;
  logic [31:0] rsp_paddr;
  logic [2:0]  rsp_cause;

  int checks = 0;
  int fails  = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] t_addr [$];
  logic        t_we   [$];
  logic [31:0] t_data [$];

  always #5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .pd_base(pd_base), .req_valid(req_valid),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_ready(req_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .rsp_paddr(rsp_paddr), .rsp_cause(rsp_cause)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] mk(input logic [19:0] frame, input logic [1:0] commit,
                                     input bit pres, input bit wr, input bit dirty);
    return {frame, 1'b0, commit, 2'b00, dirty, 4'b0000, wr, pres};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory responder: acknowledges each request one cycle after it appears
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) mem_ack = 1'b0;
      else if (mem_req && !mem_ack) begin
        mem_ack = 1'b1;
        mem_rdata = rd(mem_addr);
        t_addr.push_back(mem_addr);
        t_we.push_back(mem_we);
        t_data.push_back(mem_wdata);
        if (mem_we) mem[mem_addr] = mem_wdata;
      end else mem_ack = 1'b0;
    end
  end

  // one walk: reference model, stimulus, per-cycle checking
  task automatic walk(input logic [31:0] va, input bit wr, input string tag,
                      input bit poke);
    logic [31:0] e_addr [$];
    logic        e_we   [$];
    logic [31:0] e_data [$];
    logic [31:0] d, p, pa, exp_pa;
    logic [2:0]  exp_c;
    int cyc;
    bit seen;
    d = rd(pd_base + 32'(va[31:22]) * 4);
    e_addr.push_back(pd_base + 32'(va[31:22]) * 4); e_we.push_back(1'b0); e_data.push_back('x);
    exp_pa = 32'h0;
    if (!d[0]) exp_c = 3'd1;
    else begin
      pa = {d[31:12], 12'h000} + 32'(va[21:12]) * 4;
      p = rd(pa);
      e_addr.push_back(pa); e_we.push_back(1'b0); e_data.push_back('x);
      if (p[10:9] == 2'b00) exp_c = 3'd3;
      else if (!p[0]) exp_c = 3'd2;
      else if (wr && !(d[1] && p[1])) exp_c = 3'd4;
      else begin
        exp_c = 3'd0;
        exp_pa = {p[31:12], va[11:0]};
        if (wr && !p[6]) begin
          e_addr.push_back(pa); e_we.push_back(1'b1); e_data.push_back(p | 32'h40);
        end
      end
    end
    t_addr.delete(); t_we.delete(); t_data.delete();
    chk(req_ready === 1'b1, {"R10 ready before ", tag}, 32'(req_ready), 32'h1);
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    seen = 0;
    for (cyc = 0; cyc < 60 && !seen; cyc++) begin
      if (poke && cyc == 1) begin
        req_valid = 1'b1; req_vaddr = 32'hFFFF_FFFF; req_write = 1'b1;
      end else if (poke && cyc == 2) req_valid = 1'b0;
      if (done) begin
        seen = 1;
        chk(rsp_cause === exp_c, {"R3-cause ", tag}, 32'(rsp_cause), 32'(exp_c));
        chk(rsp_paddr === exp_pa, {"R3/R9 paddr ", tag}, rsp_paddr, exp_pa);
      end else @(negedge clk);
    end
    chk(seen, {"R9 done seen ", tag}, 32'(seen), 32'h1);
    @(negedge clk);
    chk(done === 1'b0, {"R9 single pulse ", tag}, 32'(done), 32'h0);
    repeat (3) begin
      @(negedge clk);
      chk(done === 1'b0 && mem_req === 1'b0, {"R10 quiet after ", tag},
          {done, mem_req}, 32'h0);
    end
    chk(t_addr.size() == e_addr.size(), {"R2/R4/R8 access count ", tag},
        32'(t_addr.size()), 32'(e_addr.size()));
    for (int i = 0; i < e_addr.size() && i < t_addr.size(); i++) begin
      chk(t_addr[i] === e_addr[i] && t_we[i] === e_we[i],
          {"R2/R8 access addr ", tag}, t_addr[i], e_addr[i]);
      if (e_we[i])
        chk(t_data[i] === e_data[i], {"R8 writeback data ", tag}, t_data[i], e_data[i]);
    end
  endtask

  initial begin
    #1ms;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
    pd_base = 32'h0001_0000;
    // directory: idx1 -> table 0x20000 rw, idx2 absent, idx7 -> table 0x30000 read-only
    mem[32'h0001_0004] = mk(20'h00020, 2'b10, 1, 1, 0);
    mem[32'h0001_0008] = mk(20'h00040, 2'b10, 0, 1, 0);
    mem[32'h0001_001C] = mk(20'h00030, 2'b10, 1, 0, 0);
    mem[32'h0002_000C] = mk(20'hABCDE, 2'b10, 1, 1, 0); // idx3 rw clean
    mem[32'h0002_0010] = mk(20'h12345, 2'b11, 1, 0, 0); // idx4 read-only
    mem[32'h0002_0014] = mk(20'h55555, 2'b00, 1, 1, 0); // idx5 unused
    mem[32'h0002_0018] = mk(20'h66666, 2'b01, 0, 1, 0); // idx6 reserved absent
    mem[32'h0003_0000] = mk(20'h77777, 2'b10, 1, 1, 0); // idx0 rw under ro dir
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && mem_req === 1'b0 && req_ready === 1'b1, "R1 in reset",
        {done, mem_req, req_ready}, 32'h1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done === 1'b0 && mem_req === 1'b0 && req_ready === 1'b1, "R1 after reset",
        {done, mem_req, req_ready}, 32'h1);

    walk({10'd1, 10'd3, 12'h123}, 1'b0, "R3 read ok", 0);
    walk({10'd1, 10'd3, 12'hFFF}, 1'b1, "R8 first write", 0);
    chk(mem[32'h0002_000C][6] === 1'b1, "R8 dirty in memory", mem[32'h0002_000C], 32'h40);
    walk({10'd1, 10'd3, 12'h000}, 1'b1, "R8 second write", 0);
    walk({10'd2, 10'd3, 12'h010}, 1'b0, "R4 dir absent", 0);
    walk({10'd1, 10'd5, 12'h020}, 1'b0, "R5 unused", 0);
    walk({10'd1, 10'd6, 12'h030}, 1'b1, "R6 leaf absent", 0);
    walk({10'd1, 10'd4, 12'h040}, 1'b1, "R7 ro leaf write", 0);
    walk({10'd1, 10'd4, 12'h044}, 1'b0, "R7 ro leaf read", 0);
    walk({10'd7, 10'd0, 12'h050}, 1'b1, "R7 ro dir write", 0);
    chk(mem[32'h0003_0000][6] === 1'b0, "R8 no write on fault", mem[32'h0003_0000], 32'h0);
    walk({10'd1, 10'd4, 12'h060}, 1'b0, "R10 busy poke", 1);
    walk({10'd1, 10'd3, 12'h070}, 1'b0, "R11 stable walk", 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule